// File: doc/BRIEF.md
# GPIO Port Interrupt Controller

This block watches three 8-line general-purpose input ports, called A, B and F, and turns pin activity into interrupt requests. For each line, software picks level or edge sensing and the active sense: low or falling, or high or rising. It also sets an enable bit and can switch on a debounce filter. Every pin passes through a two-flop synchroniser. When the debounce filter is on, a new level is taken only after it has been seen on four consecutive samples of an internal slow strobe.

An edge event is held in a per-line latch until software writes a one to that line's bit in the acknowledge register. A level event simply follows the filtered pin. Each port has a status register that shows which enabled lines are pending. The requests of ports A and B are combined onto one shared output, so a handler reads both status registers to find the source. Each port F line drives an output of its own.

Register access is a simple single-cycle bus. A write is sampled on the rising clock edge when `we_i` is high. Read data is combinational from the address. The address is `{port, reg}`: port 0 is A, 1 is B and 2 is F. The register codes are 0 mode, 1 polarity, 2 acknowledge, 3 enable, 4 debounce and 5 status.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every mode, polarity, enable, debounce and status register reads 0, and irq_ab_o and irq_f_o are low.
- R2: The register codes are mode 0, polarity 1, enable 3 and debounce 4. Each of these reads back the value last written at address {port[1:0], code[2:0]}, with port A=0, B=1 and F=2. The acknowledge register (code 2) and any unused code read 0.
- R3: In level mode (mode bit 0), a line's status bit (code 5) is 1 exactly when the line is enabled and the synchronised pin equals its polarity bit. A polarity of 1 means active high and 0 means active low. Status settles within 4 clock cycles of a pin change.
- R4: In edge mode (mode bit 1), an enabled line latches a rising edge when its polarity bit is 1, or a falling edge when it is 0. The status bit stays 1 after the pin returns. A line in level mode never sets its latch.
- R5: Writing the acknowledge register clears the latch of every line whose data bit is 1 and leaves lines with a 0 bit unchanged. If a new edge arrives in the same cycle as the acknowledge, the latch stays set.
- R6: A disabled line has status 0 and drives no output. It never sets its latch. Changing its mode or polarity while it is disabled creates no event.
- R7: irq_ab_o is the OR of the port A and port B status bits. irq_f_o[i] equals port F status bit i.
- R8: With a line's debounce bit set, a pin level takes effect only after 4 consecutive strobe samples. A pulse shorter than that leaves the status unchanged.
- R9: A latched edge is kept while its line is disabled and shows again in status once the line is re-enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register address {port[1:0], code[2:0]} |
| wdata_i | input | 8 | Write data, one bit per line |
| rdata_o | output | 8 | Read data for addr_i |
| pins_i | input | 24 | Pins: A in [7:0], B in [15:8], F in [23:16] |
| irq_ab_o | output | 1 | Shared request of ports A and B |
| irq_f_o | output | 8 | Per-line requests of port F |

## Verification
A wrong edge latch or enable register shows up directly on the status readback and on irq_ab_o or irq_f_o. This happens within four clock cycles of the pin change, or in the cycle after the register write. A lost acknowledge or a spurious latch persists indefinitely, so it is still visible at the next status read. A faulty debounce counter shows as a status bit that changes after a short pulse, or that never changes even after 64 cycles of a stable level.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int NUM_PORTS = 3;
  localparam int PORT_A = 0;
  localparam int PORT_B = 1;
  localparam int PORT_F = 2;
  localparam int REG_W = 3;

  typedef enum logic [REG_W-1:0] {
    REG_MODE = 3'd0,
    REG_POL  = 3'd1,
    REG_ACK  = 3'd2,
    REG_EN   = 3'd3,
    REG_DBNC = 3'd4,
    REG_STAT = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_irq_dbnc.sv
module gpio_irq_dbnc #(
  parameter int W        = 8,
  parameter int DBNC_LEN = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int CW = (DBNC_LEN > 2) ? $clog2(DBNC_LEN) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DBNC_LEN - 1);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [CW-1:0] cnt_q;
    logic          lvl_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= '0;
        lvl_q <= 1'b0;
      end else if (tick_i) begin
        if (d_i[i] != lvl_q) begin
          if (cnt_q == CNT_LAST) begin
            lvl_q <= d_i[i];
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else begin
          cnt_q <= '0;
        end
      end
    end

    assign q_o[i] = lvl_q;
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int LINES    = 8,
  parameter int DBNC_LEN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  reg_sel_e         sel_i,
  input  logic [LINES-1:0] wdata_i,
  input  logic [LINES-1:0] pin_i,
  input  logic             tick_i,
  output logic [LINES-1:0] mode_o,
  output logic [LINES-1:0] pol_o,
  output logic [LINES-1:0] en_o,
  output logic [LINES-1:0] dbnc_o,
  output logic [LINES-1:0] status_o,
  output logic [LINES-1:0] edge_o
);
  logic [LINES-1:0] mode_q, pol_q, en_q, dbnc_q;
  logic [LINES-1:0] pin_db, filt, prev_q, edge_q;
  logic [LINES-1:0] rise, fall, hit, set_ev, ack, active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      pol_q  <= '0;
      en_q   <= '0;
      dbnc_q <= '0;
    end else if (wr_i) begin
      unique case (sel_i)
        REG_MODE: mode_q <= wdata_i;
        REG_POL:  pol_q  <= wdata_i;
        REG_EN:   en_q   <= wdata_i;
        REG_DBNC: dbnc_q <= wdata_i;
        default:  ;
      endcase
    end
  end

  gpio_irq_dbnc #(.W(LINES), .DBNC_LEN(DBNC_LEN)) u_dbnc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .d_i    (pin_i),
    .q_o    (pin_db)
  );

  assign filt = (dbnc_q & pin_db) | (~dbnc_q & pin_i);

  // previous level tracked always, so enabling or retyping never fakes an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= filt;
  end

  assign rise   = filt & ~prev_q;
  assign fall   = ~filt & prev_q;
  assign hit    = (pol_q & rise) | (~pol_q & fall);
  assign set_ev = hit & mode_q & en_q;
  assign ack    = (wr_i && sel_i == REG_ACK) ? wdata_i : '0;

  // new event beats a simultaneous acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) edge_q <= '0;
    else         edge_q <= (edge_q & ~ack) | set_ev;
  end

  assign active   = ~(filt ^ pol_q);
  assign status_o = en_q & ((mode_q & edge_q) | (~mode_q & active));
  assign mode_o   = mode_q;
  assign pol_o    = pol_q;
  assign en_o     = en_q;
  assign dbnc_o   = dbnc_q;
  assign edge_o   = edge_q;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int LINES    = 8,
  parameter int DBNC_DIV = 8,
  parameter int DBNC_LEN = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [REG_W+1:0]           addr_i,
  input  logic [LINES-1:0]           wdata_i,
  output logic [LINES-1:0]           rdata_o,
  input  logic [NUM_PORTS*LINES-1:0] pins_i,
  output logic                       irq_ab_o,
  output logic [LINES-1:0]           irq_f_o
);
  localparam int ADDR_W = REG_W + 2;
  localparam int TOTAL  = NUM_PORTS * LINES;
  localparam int DIVW   = (DBNC_DIV > 2) ? $clog2(DBNC_DIV) : 1;
  localparam logic [DIVW-1:0] DIV_LAST = DIVW'(DBNC_DIV - 1);

  logic [DIVW-1:0] div_q;
  logic            tick;
  logic [TOTAL-1:0] pins_sync, en_all, mode_all, edge_all;
  logic [1:0]      addr_port;
  reg_sel_e        addr_reg;

  logic [LINES-1:0] mode_p [NUM_PORTS];
  logic [LINES-1:0] pol_p  [NUM_PORTS];
  logic [LINES-1:0] en_p   [NUM_PORTS];
  logic [LINES-1:0] dbnc_p [NUM_PORTS];
  logic [LINES-1:0] stat_p [NUM_PORTS];
  logic [LINES-1:0] edge_p [NUM_PORTS];

  assign addr_port = addr_i[ADDR_W-1:REG_W];
  assign addr_reg  = reg_sel_e'(addr_i[REG_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              div_q <= '0;
    else if (div_q == DIV_LAST) div_q <= '0;
    else                      div_q <= div_q + 1'b1;
  end
  assign tick = (div_q == DIV_LAST);

  gpio_irq_sync #(.W(TOTAL)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pins_i),
    .q_o    (pins_sync)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic wr_sel;
    assign wr_sel = we_i && (addr_port == 2'(p));

    gpio_irq_port #(.LINES(LINES), .DBNC_LEN(DBNC_LEN)) u_port (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (wr_sel),
      .sel_i    (addr_reg),
      .wdata_i  (wdata_i),
      .pin_i    (pins_sync[p*LINES +: LINES]),
      .tick_i   (tick),
      .mode_o   (mode_p[p]),
      .pol_o    (pol_p[p]),
      .en_o     (en_p[p]),
      .dbnc_o   (dbnc_p[p]),
      .status_o (stat_p[p]),
      .edge_o   (edge_p[p])
    );

    assign en_all[p*LINES +: LINES]   = en_p[p];
    assign mode_all[p*LINES +: LINES] = mode_p[p];
    assign edge_all[p*LINES +: LINES] = edge_p[p];
  end

  always_comb begin
    rdata_o = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (addr_port == 2'(p)) begin
        unique case (addr_reg)
          REG_MODE: rdata_o = mode_p[p];
          REG_POL:  rdata_o = pol_p[p];
          REG_EN:   rdata_o = en_p[p];
          REG_DBNC: rdata_o = dbnc_p[p];
          REG_STAT: rdata_o = stat_p[p];
          default:  rdata_o = '0;
        endcase
      end
    end
  end

  assign irq_ab_o = |(stat_p[PORT_A] | stat_p[PORT_B]);
  assign irq_f_o  = stat_p[PORT_F];
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
  parameter int LINES = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 we_i,
  input logic [4:0]           addr_i,
  input logic [LINES-1:0]     wdata_i,
  input logic                 irq_ab_o,
  input logic [LINES-1:0]     irq_f_o,
  input logic [3*LINES-1:0]   en_all,
  input logic [3*LINES-1:0]   mode_all,
  input logic [3*LINES-1:0]   edge_all
);
  assert_ab_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ab_o |-> |en_all[2*LINES-1:0]);

  for (genvar i = 0; i < LINES; i++) begin : g_f
    assert_f_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_all[2*LINES+i] |-> !irq_f_o[i]);
  end

  for (genvar j = 0; j < 3*LINES; j++) begin : g_line
    localparam int P = j / LINES;
    localparam int B = j % LINES;
    logic ack_j;
    assign ack_j = we_i && (addr_i[4:3] == 2'(P)) && (addr_i[2:0] == 3'd2) && wdata_i[B];

    assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      edge_all[j] && !ack_j |=> edge_all[j]);

    assert_noset_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_all[j] && !edge_all[j] |=> !edge_all[j]);

    assert_lvl_nolatch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !mode_all[j] && !edge_all[j] |=> !edge_all[j]);
  end
endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.LINES(LINES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .irq_ab_o (irq_ab_o),
  .irq_f_o  (irq_f_o),
  .en_all   (en_all),
  .mode_all (mode_all),
  .edge_all (edge_all)
);

// File: tb/gpio_irq_ctrl_test.sv
module gpio_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int L = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [23:0] pins = '0;
  logic        irq_ab;
  logic [7:0]  irq_f;

  int total = 0;
  int bad = 0;
  bit done = 0;

  gpio_irq_ctrl uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .we_i     (we),
    .addr_i   (addr),
    .wdata_i  (wdata),
    .rdata_o  (rdata),
    .pins_i   (pins),
    .irq_ab_o (irq_ab),
    .irq_f_o  (irq_f)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [4:0] ad(int p, int r);
    return {2'(p), 3'(r)};
  endfunction

  function automatic logic [7:0] lvl_exp(logic [7:0] pin, logic [7:0] pol, logic [7:0] en);
    return en & ~(pin ^ pol);
  endfunction

  function automatic logic [7:0] edge_exp(logic [7:0] p0, logic [7:0] p1,
                                          logic [7:0] pol, logic [7:0] en);
    return en & ((pol & p1 & ~p0) | (~pol & ~p1 & p0));
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  task automatic clear_all();
    for (int p = 0; p < 3; p++) begin
      wr(ad(p, 3), 8'h00);
      wr(ad(p, 0), 8'h00);
      wr(ad(p, 1), 8'h00);
      wr(ad(p, 4), 8'h00);
      wr(ad(p, 2), 8'hFF);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] pol [3];
    logic [7:0] en [3];
    logic [7:0] lat [3];
    logic [7:0] st [3];
    logic [23:0] prev;

    void'($urandom(32'd7391));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    for (int p = 0; p < 3; p++)
      for (int r = 0; r < 6; r++) begin
        rd(ad(p, r), d);
        check($sformatf("R1 port%0d reg%0d", p, r), 32'(d), 32'h0);
      end
    check("R1 irq_ab", 32'(irq_ab), 32'h0);
    check("R1 irq_f", 32'(irq_f), 32'h0);

    // R2 readback
    wr(ad(1, 0), 8'h5A); wr(ad(1, 1), 8'hC3); wr(ad(1, 3), 8'h0F); wr(ad(1, 4), 8'h81);
    rd(ad(1, 0), d); check("R2 mode", 32'(d), 32'h5A);
    rd(ad(1, 1), d); check("R2 pol", 32'(d), 32'hC3);
    rd(ad(1, 3), d); check("R2 en", 32'(d), 32'h0F);
    rd(ad(1, 4), d); check("R2 dbnc", 32'(d), 32'h81);
    rd(ad(1, 2), d); check("R2 ack reads 0", 32'(d), 32'h0);
    rd(ad(1, 6), d); check("R2 unused reads 0", 32'(d), 32'h0);
    rd(ad(0, 0), d); check("R2 other port mode", 32'(d), 32'h0);
    clear_all();

    // R3 / R7 random level patterns
    for (int it = 0; it < 30; it++) begin
      for (int p = 0; p < 3; p++) begin
        pol[p] = 8'($urandom); en[p] = 8'($urandom);
        wr(ad(p, 1), pol[p]); wr(ad(p, 3), en[p]);
      end
      @(negedge clk) pins = 24'($urandom);
      settle();
      for (int p = 0; p < 3; p++) begin
        rd(ad(p, 5), d);
        check($sformatf("R3 level status port%0d", p), 32'(d),
              32'(lvl_exp(pins[p*L +: L], pol[p], en[p])));
      end
      check("R7 irq_ab level", 32'(irq_ab),
            32'(|(lvl_exp(pins[7:0], pol[0], en[0]) | lvl_exp(pins[15:8], pol[1], en[1]))));
      check("R7 irq_f level", 32'(irq_f), 32'(lvl_exp(pins[23:16], pol[2], en[2])));
    end

    // R4 / R5 random edges
    for (int p = 0; p < 3; p++) begin
      wr(ad(p, 3), 8'h00);
      wr(ad(p, 0), 8'hFF);
      pol[p] = 8'($urandom); en[p] = 8'($urandom);
      wr(ad(p, 1), pol[p]);
      wr(ad(p, 2), 8'hFF);
      wr(ad(p, 3), en[p]);
      lat[p] = 8'h00;
    end
    for (int it = 0; it < 40; it++) begin
      prev = pins;
      @(negedge clk) pins = 24'($urandom);
      settle();
      for (int p = 0; p < 3; p++)
        lat[p] = lat[p] | edge_exp(prev[p*L +: L], pins[p*L +: L], pol[p], en[p]);
      if (it % 4 == 3) begin
        for (int p = 0; p < 3; p++) begin
          d = 8'($urandom);
          wr(ad(p, 2), d);
          lat[p] = lat[p] & ~d;
        end
      end
      for (int p = 0; p < 3; p++) begin
        rd(ad(p, 5), st[p]);
        check($sformatf("R4 R5 edge status port%0d", p), 32'(st[p]), 32'(lat[p]));
      end
      check("R7 irq_ab edge", 32'(irq_ab), 32'(|(lat[0] | lat[1])));
      check("R7 irq_f edge", 32'(irq_f), 32'(lat[2]));
    end

    // R5 directed: ack zero bits keep, same-cycle edge wins
    clear_all();
    @(negedge clk) pins = '0;
    settle();
    wr(ad(0, 0), 8'h01); wr(ad(0, 1), 8'h01); wr(ad(0, 3), 8'h01);
    @(negedge clk) pins[0] = 1'b1;
    settle();
    rd(ad(0, 5), d); check("R4 rising latched", 32'(d), 32'h01);
    @(negedge clk) pins[0] = 1'b0;
    settle();
    rd(ad(0, 5), d); check("R4 held after pin return", 32'(d), 32'h01);
    wr(ad(0, 2), 8'hFE);
    rd(ad(0, 5), d); check("R5 ack zero bit no effect", 32'(d), 32'h01);
    @(negedge clk) pins[0] = 1'b1;
    @(posedge clk); @(posedge clk);
    wr(ad(0, 2), 8'h01);
    rd(ad(0, 5), d); check("R5 edge wins over ack", 32'(d), 32'h01);
    wr(ad(0, 2), 8'h01);
    rd(ad(0, 5), d); check("R5 ack clears", 32'(d), 32'h00);
    check("R7 irq_ab after ack", 32'(irq_ab), 32'h0);

    // R4 falling polarity and level-mode no latch
    wr(ad(0, 1), 8'h00);
    @(negedge clk) pins[0] = 1'b0;
    settle();
    rd(ad(0, 5), d); check("R4 falling latched", 32'(d), 32'h01);
    wr(ad(0, 2), 8'h01);
    wr(ad(0, 0), 8'h00); wr(ad(0, 1), 8'h02); wr(ad(0, 3), 8'h02);
    @(negedge clk) pins[1] = 1'b1;
    settle();
    @(negedge clk) pins[1] = 1'b0;
    settle();
    wr(ad(0, 0), 8'h02);
    rd(ad(0, 5), d); check("R4 level mode sets no latch", 32'(d), 32'h00);

    // R6 disabled line in port F
    clear_all();
    wr(ad(2, 0), 8'h00); wr(ad(2, 1), 8'h08);
    @(negedge clk) pins[19] = 1'b1;
    settle();
    check("R6 disabled level no output", 32'(irq_f), 32'h00);
    rd(ad(2, 5), d); check("R6 disabled status", 32'(d), 32'h00);
    wr(ad(2, 0), 8'h08);
    @(negedge clk) pins[19] = 1'b0;
    settle();
    @(negedge clk) pins[19] = 1'b1;
    settle();
    wr(ad(2, 1), 8'h00); wr(ad(2, 1), 8'h08);
    wr(ad(2, 3), 8'h08);
    settle();
    check("R6 no event from disabled period", 32'(irq_f), 32'h00);
    rd(ad(2, 5), d); check("R6 status after enable", 32'(d), 32'h00);

    // R9 latch retained over disable
    @(negedge clk) pins[19] = 1'b0;
    settle();
    @(negedge clk) pins[19] = 1'b1;
    settle();
    check("R9 latched irq_f", 32'(irq_f), 32'h08);
    wr(ad(2, 3), 8'h00);
    check("R9 hidden while disabled", 32'(irq_f), 32'h00);
    wr(ad(2, 3), 8'h08);
    check("R9 back after enable", 32'(irq_f), 32'h08);
    wr(ad(2, 2), 8'h08);

    // R8 debounce
    clear_all();
    @(negedge clk) pins = '0;
    settle();
    wr(ad(0, 0), 8'h00); wr(ad(0, 1), 8'h02); wr(ad(0, 4), 8'h02); wr(ad(0, 3), 8'h02);
    repeat (40) @(posedge clk);
    @(negedge clk) pins[1] = 1'b1;
    repeat (16) @(posedge clk);
    @(negedge clk) pins[1] = 1'b0;
    repeat (80) @(posedge clk);
    rd(ad(0, 5), d); check("R8 short pulse ignored", 32'(d), 32'h00);
    check("R8 short pulse no irq", 32'(irq_ab), 32'h0);
    @(negedge clk) pins[1] = 1'b1;
    repeat (12) @(posedge clk);
    rd(ad(0, 5), d); check("R8 not yet accepted", 32'(d), 32'h00);
    repeat (52) @(posedge clk);
    rd(ad(0, 5), d); check("R8 stable level accepted", 32'(d), 32'h02);
    check("R8 irq_ab after debounce", 32'(irq_ab), 32'h1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule